// File: doc/BRIEF.md
# Power-of-Two Modulo and Remainder Reducer

This combinational block reduces an N-bit operand by a fixed divisor of 2^K. It returns two results in parallel: a floored modulo and a truncated remainder. Both come from the operand's low K bits, so there is no divider. The reducer sits on a datapath where an index has to be folded into a power-of-two range. It also serves a signed accumulator that needs the C-style remainder.

A mode input selects whether the operand is read as an unsigned number or as a two's-complement number. The modulo result is always non-negative and smaller than 2^K. The remainder carries the sign of the operand and is sign-extended to N bits. In unsigned mode the two results are identical. For a negative operand they can differ: reducing -3 by 8 gives a modulo of 5 and a remainder of -3. Negating before the reduction is therefore not the same as negating after it.

The divisor exponent K is a parameter with 1 <= K < N. There are no registers.

Top module: `pow2_modrem`

## Requirements
- R1: `mod_o` equals the operand's low K bits, with every bit from K upward zero, in both modes.
- R2: With `signed_mode_i` = 1, `mod_o` is the floored modulo of the two's-complement operand by 2^K, a value in 0 to 2^K-1 (for N=8, K=3: operand 8'hFD (-3) gives 5).
- R3: With `signed_mode_i` = 0, `rem_o` equals `mod_o` for every operand.
- R4: With `signed_mode_i` = 1 and operand bit N-1 clear, `rem_o` equals `mod_o`.
- R5: With `signed_mode_i` = 1, operand bit N-1 set and low K bits nonzero, `rem_o` is the low K bits minus 2^K, sign-extended to N bits (for N=8, K=3: 8'h81 gives 8'hF9).
- R6: With `signed_mode_i` = 1, operand bit N-1 set and low K bits all zero, `rem_o` is zero.
- R7: With `signed_mode_i` = 1, `rem_o` is the remainder of division truncated toward zero: it is zero or has the operand's sign, and its magnitude is below 2^K.
- R8: With `signed_mode_i` = 1, the remainder of the negated operand equals the negated remainder of the operand, while the modulo of the negated operand equals 2^K minus the modulo whenever that modulo is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | N | Value to be reduced |
| signed_mode_i | input | 1 | 1 reads the operand as two's complement, 0 as unsigned |
| mod_o | output | N | Floored modulo by 2^K, always non-negative |
| rem_o | output | N | Truncated remainder, sign-extended in signed mode |

## Verification
Every 8-bit operand is applied in both modes, and both results are compared with values computed from integer division and modulo. This sweep separates the unsigned case from positive signed operands, and negative operands with nonzero low bits from negative multiples of 2^K, including the most negative value. Pairs of an operand and its negation are then compared with each other, showing that the remainder is odd-symmetric while the modulo is not. A short table of hand-picked vectors pins down the cases where the two results are easy to confuse.

// File: rtl/pow2_modrem_pkg.sv
package pow2_modrem_pkg;

    typedef enum logic {
        RED_UNSIGNED = 1'b0,
        RED_SIGNED   = 1'b1
    } red_mode_e;

    typedef struct packed {
        logic negative;   // operand is below zero under the selected reading
        logic low_zero;   // kept bits are all zero
    } op_class_t;

    function automatic logic sign_of(input logic msb, input red_mode_e mode);
        return (mode == RED_SIGNED) && msb;
    endfunction

endpackage

// File: rtl/pow2_low_keep.sv
module pow2_low_keep #(
    parameter int unsigned N = 8,
    parameter int unsigned K = 3
) (
    input  logic [N-1:0] value_i,
    output logic [N-1:0] kept_o
);
    localparam int unsigned HI_W = N - K;
    localparam logic [N-1:0] KEEP_MASK = {{HI_W{1'b0}}, {K{1'b1}}};

    always_comb begin
        kept_o = value_i & KEEP_MASK;
    end
endmodule

// File: rtl/pow2_operand_class.sv
module pow2_operand_class
    import pow2_modrem_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned K = 3
) (
    input  logic [N-1:0] value_i,
    input  red_mode_e    mode_i,
    output op_class_t    class_o
);
    always_comb begin
        class_o.negative = sign_of(value_i[N-1], mode_i);
        class_o.low_zero = ~|value_i[K-1:0];
    end
endmodule

// File: rtl/pow2_rem_adjust.sv
module pow2_rem_adjust
    import pow2_modrem_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned K = 3
) (
    input  logic [N-1:0] kept_i,
    input  op_class_t    class_i,
    output logic [N-1:0] rem_o
);
    localparam int unsigned HI_W = N - K;

    logic borrow;

    always_comb begin
        // a negative operand with a nonzero residue borrows one divisor
        borrow = class_i.negative && !class_i.low_zero;
        if (borrow) begin
            rem_o = {{HI_W{1'b1}}, kept_i[K-1:0]};
        end else begin
            rem_o = kept_i;
        end
    end
endmodule

// File: rtl/pow2_modrem.sv
module pow2_modrem
    import pow2_modrem_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned K = 3
) (
    input  logic [N-1:0] operand_i,
    input  logic         signed_mode_i,
    output logic [N-1:0] mod_o,
    output logic [N-1:0] rem_o
);
    localparam int unsigned HI_W = N - K;
    localparam logic [N-1:0] DIVISOR = {{(HI_W-1){1'b0}}, 1'b1, {K{1'b0}}};

    red_mode_e   mode;
    op_class_t   op_class;
    logic [N-1:0] kept;

    assign mode = red_mode_e'(signed_mode_i);

    pow2_low_keep #(.N(N), .K(K)) u_keep (
        .value_i (operand_i),
        .kept_o  (kept)
    );

    pow2_operand_class #(.N(N), .K(K)) u_class (
        .value_i (operand_i),
        .mode_i  (mode),
        .class_o (op_class)
    );

    pow2_rem_adjust #(.N(N), .K(K)) u_adjust (
        .kept_i  (kept),
        .class_i (op_class),
        .rem_o   (rem_o)
    );

    assign mod_o = kept;

    always_comb begin
        a_r1_mod_upper_clear: assert ((mod_o >> K) == '0)
            else $error("R1: modulo has bits set above K");
        a_r1_mod_low_match: assert (mod_o[K-1:0] == operand_i[K-1:0])
            else $error("R1: modulo low bits differ from operand");
        if (!signed_mode_i) begin
            a_r3_unsigned_equal: assert (rem_o == mod_o)
                else $error("R3: remainder differs from modulo in unsigned mode");
        end
        if (signed_mode_i && !operand_i[N-1]) begin
            a_r4_nonneg_equal: assert (rem_o == mod_o)
                else $error("R4: remainder differs for non-negative operand");
        end
        if (signed_mode_i && operand_i[N-1] && (operand_i[K-1:0] != '0)) begin
            a_r5_neg_borrow: assert (N'(rem_o + DIVISOR) == mod_o)
                else $error("R5: remainder is not modulo minus divisor");
        end
        if (signed_mode_i && operand_i[N-1] && (operand_i[K-1:0] == '0)) begin
            a_r6_neg_multiple: assert (rem_o == '0)
                else $error("R6: remainder not zero for negative multiple");
        end
        if (signed_mode_i && (rem_o != '0)) begin
            a_r7_rem_sign: assert (rem_o[N-1] == operand_i[N-1])
                else $error("R7: remainder sign differs from operand sign");
        end
    end
endmodule

// File: tb/pow2_modrem_tb.sv
module pow2_modrem_tb;
    localparam int N = 8;
    localparam int K = 3;
    localparam int DIV = 1 << K;

    typedef struct packed {
        logic [7:0] op;
        logic       sm;
        logic [7:0] exp_mod;
        logic [7:0] exp_rem;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{8'hFD, 1'b1, 8'h05, 8'hFD},
        '{8'h03, 1'b1, 8'h03, 8'h03},
        '{8'hF8, 1'b1, 8'h00, 8'h00},
        '{8'h80, 1'b1, 8'h00, 8'h00},
        '{8'h81, 1'b1, 8'h01, 8'hF9},
        '{8'hFD, 1'b0, 8'h05, 8'h05},
        '{8'h7F, 1'b1, 8'h07, 8'h07},
        '{8'hFF, 1'b1, 8'h07, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] operand;
    logic         smode;
    logic [N-1:0] mod_q;
    logic [N-1:0] rem_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pow2_modrem #(.N(N), .K(K)) u_dut (
        .operand_i     (operand),
        .signed_mode_i (smode),
        .mod_o         (mod_q),
        .rem_o         (rem_q)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: op=%h mode=%0d actual=%0d expected=%0d",
                     req, operand, smode, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] op, input logic sm);
        @(negedge clk);
        operand = op;
        smode   = sm;
        #1;
    endtask

    initial begin
        operand = '0;
        smode   = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state with a zero operand: both results zero
        apply(8'h00, 1'b0);
        check("R1 reset mod", int'(mod_q), 0);
        check("R3 reset rem", int'(rem_q), 0);

        // hand-picked vectors
        for (int i = 0; i < 8; i++) begin
            apply(TABLE[i].op, TABLE[i].sm);
            check("R1/R2 table mod", int'(mod_q), int'(TABLE[i].exp_mod));
            check("R5/R6/R7 table rem", int'(rem_q), int'(TABLE[i].exp_rem));
        end

        // exhaustive sweep in both modes against integer arithmetic
        for (int v = 0; v < (1 << N); v++) begin
            for (int m = 0; m < 2; m++) begin
                int sx;
                int er;
                int em;
                apply(N'(v), m[0]);
                if (m == 0) begin
                    check("R1 unsigned mod", int'(mod_q), v % DIV);
                    check("R3 unsigned rem", int'(rem_q), v % DIV);
                end else begin
                    sx = int'($signed(N'(v)));
                    er = sx % DIV;
                    em = (er < 0) ? er + DIV : er;
                    check("R2 signed mod", int'(mod_q), em);
                    if (sx >= 0)
                        check("R4 nonneg rem", int'($signed(rem_q)), er);
                    else if ((sx % DIV) != 0)
                        check("R5 neg rem", int'($signed(rem_q)), er);
                    else
                        check("R6 neg multiple rem", int'($signed(rem_q)), 0);
                    check("R7 rem sign ok",
                          int'((rem_q == '0) || (rem_q[N-1] == (sx < 0))), 1);
                end
            end
        end

        // negation before versus after reduction
        for (int v = 1; v < (1 << (N - 1)); v++) begin
            int r_pos;
            int m_pos;
            int r_neg;
            int m_neg;
            apply(N'(v), 1'b1);
            r_pos = int'($signed(rem_q));
            m_pos = int'(mod_q);
            apply(N'(-v), 1'b1);
            r_neg = int'($signed(rem_q));
            m_neg = int'(mod_q);
            check("R8 rem odd symmetry", r_neg, -r_pos);
            check("R8 mod reflection", m_neg, (m_pos == 0) ? 0 : DIV - m_pos);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule